// File: doc/BRIEF.md
# Trap-Triggered Tap Serializer

This block copies chosen intermediate values out of a running signal-processing core and streams them on one serial data pin. Two trap registers, one per output channel, are loaded through a simple control write port. Each step the core presents the program counter of the instruction it is executing and the data word that instruction produced. When the program counter equals a channel's trap value, that word is caught in the channel's holding register.

The holding registers are emptied into a parallel-to-serial shifter at the start of each half-frame of the serial input port's word clock. Bits leave on the falling edge of that port's bit clock, so the output pin and the two input-port clocks together form a valid three-wire audio stream. The frame format follows a format select pin: I2S, where the MSB comes one bit clock after the word-clock edge, or left-justified, where it comes on that edge. Both serial clocks are far slower than the system clock and are sampled into it.

The tap input carries a valid strobe and no ready: the block never applies back-pressure, every step with `tap_valid` high is examined in the cycle it is presented, and a step is never stalled or dropped.

Top module: `dcs_capture_top`

## Requirements
- R1: A control write with `cfg_addr` = 263 loads the left trap from `cfg_wdata`; a write with `cfg_addr` = 264 loads the right trap; each takes effect in the next cycle.
- R2: A control write to any other address leaves both traps unchanged.
- R3: A step with `tap_valid` high and `tap_pc` equal to a trap stores `tap_data` in that channel's holding register in the next cycle; a step with `tap_valid` low stores nothing.
- R4: When several steps hit one trap before a half-frame starts, the last one is sent; when both traps hold the same value, one step fills both channels.
- R5: With `fmt` = 0 (I2S), `lrclk` low is the left half and high the right; the first bit slot after the word-clock edge is 0 and the MSB sits in the second slot, bits changing only after `bclk` falling edges.
- R6: With `fmt` = 1 (left-justified), `lrclk` high is the left half and low the right; the MSB sits in the first slot of the half.
- R7: Words are 24 bits, sent MSB first; every slot after the LSB until the next half-frame is 0.
- R8: A channel with no trap hit since its last half-frame repeats its previous word.
- R9: After reset the traps and holding registers are 0 and `sdout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 1 | Frame format: 0 = I2S, 1 = left-justified |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 9 | Control write address |
| cfg_wdata | input | 10 | Trap value to write |
| tap_valid | input | 1 | Core step valid |
| tap_pc | input | 10 | Program counter of the current step |
| tap_data | input | 24 | Data word of the current step |
| bclk | input | 1 | Serial input port bit clock |
| lrclk | input | 1 | Serial input port word clock |
| sdout | output | 1 | Serial tap data |

## Verification
Directed frames cover the empty state after reset, one clean hit per channel, a frame with no hit, a write to a neighbouring address, a matching step with valid low, repeated hits and shared traps, which separates dropped captures from stale or early ones. Random program-counter streams that hit either, both or neither trap at random points then run in I2S and again in left-justified mode, so a slot shifted by one, a swapped channel polarity or missing zero fill shows up as a slot mismatch against the bench's own frame model.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int TRAP_L_ADDR = 263;
  localparam int TRAP_R_ADDR = 264;
  typedef enum logic {FMT_I2S = 1'b0, FMT_LJ = 1'b1} fmt_e;
endpackage

// File: rtl/dcs_trap_regs.sv
module dcs_trap_regs #(
  parameter int ADDR_W = 9,
  parameter int PC_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [PC_W-1:0]   cfg_wdata,
  output logic [PC_W-1:0]   trap_l,
  output logic [PC_W-1:0]   trap_r
);
  import dcs_pkg::*;
  localparam logic [ADDR_W-1:0] A_L = ADDR_W'(TRAP_L_ADDR);
  localparam logic [ADDR_W-1:0] A_R = ADDR_W'(TRAP_R_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_l <= '0;
      trap_r <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_L) trap_l <= cfg_wdata;
      if (cfg_addr == A_R) trap_r <= cfg_wdata;
    end
  end
endmodule

// File: rtl/dcs_capture.sv
module dcs_capture #(
  parameter int PC_W = 10,
  parameter int DW   = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tap_valid,
  input  logic [PC_W-1:0] tap_pc,
  input  logic [DW-1:0]   tap_data,
  input  logic [PC_W-1:0] trap_l,
  input  logic [PC_W-1:0] trap_r,
  output logic [DW-1:0]   hold_l,
  output logic [DW-1:0]   hold_r
);
  localparam int NCH = 2;
  logic [PC_W-1:0] trap [NCH];
  logic [DW-1:0]   hold [NCH];

  assign trap[0] = trap_l;
  assign trap[1] = trap_r;
  assign hold_l  = hold[0];
  assign hold_r  = hold[1];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)
        hold[ch] <= '0;
      else if (tap_valid && tap_pc == trap[ch])
        hold[ch] <= tap_data;
    end
  end
endmodule

// File: rtl/dcs_serializer.sv
module dcs_serializer #(
  parameter int DW   = 24,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fmt,
  input  logic          bclk,
  input  logic          lrclk,
  input  logic [DW-1:0] hold_l,
  input  logic [DW-1:0] hold_r,
  output logic          bit_fall,
  output logic          sdout
);
  import dcs_pkg::*;
  localparam int BW = SYNC + 1;

  logic [BW-1:0]   bclk_s;
  logic [SYNC-1:0] lr_s;
  logic            lr_now, lr_last, left_half;
  logic [DW-1:0]   sr, word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_s <= '1;
      lr_s   <= '1;
    end else begin
      bclk_s <= {bclk_s[BW-2:0], bclk};
      lr_s   <= {lr_s[SYNC-2:0], lrclk};
    end
  end

  assign bit_fall  = bclk_s[BW-1] & ~bclk_s[BW-2];
  assign lr_now    = lr_s[SYNC-1];
  assign left_half = (fmt == FMT_I2S) ? ~lr_now : lr_now;
  assign word      = left_half ? hold_l : hold_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_last <= 1'b1;
      sr      <= '0;
      sdout   <= 1'b0;
    end else if (bit_fall) begin
      if (lr_now != lr_last) begin
        lr_last <= lr_now;
        if (fmt == FMT_I2S) begin
          sdout <= 1'b0;
          sr    <= word;
        end else begin
          sdout <= word[DW-1];
          sr    <= word << 1;
        end
      end else begin
        sdout <= sr[DW-1];
        sr    <= sr << 1;
      end
    end
  end
endmodule

// File: rtl/dcs_capture_top.sv
module dcs_capture_top #(
  parameter int ADDR_W = 9,
  parameter int PC_W   = 10,
  parameter int DW     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [PC_W-1:0]   cfg_wdata,
  input  logic              tap_valid,
  input  logic [PC_W-1:0]   tap_pc,
  input  logic [DW-1:0]     tap_data,
  input  logic              bclk,
  input  logic              lrclk,
  output logic              sdout
);
  logic [PC_W-1:0] trap_l, trap_r;
  logic [DW-1:0]   hold_l, hold_r;
  logic            bit_fall;

  dcs_trap_regs #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_traps (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trap_l(trap_l), .trap_r(trap_r)
  );

  dcs_capture #(.PC_W(PC_W), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .tap_valid(tap_valid), .tap_pc(tap_pc),
    .tap_data(tap_data), .trap_l(trap_l), .trap_r(trap_r),
    .hold_l(hold_l), .hold_r(hold_r)
  );

  dcs_serializer #(.DW(DW)) u_ser (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .bclk(bclk), .lrclk(lrclk),
    .hold_l(hold_l), .hold_r(hold_r), .bit_fall(bit_fall), .sdout(sdout)
  );
endmodule

// File: rtl/dcs_capture_chk.sv
module dcs_capture_chk #(
  parameter int ADDR_W = 9,
  parameter int PC_W   = 10,
  parameter int DW     = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [PC_W-1:0]   cfg_wdata,
  input logic              tap_valid,
  input logic [PC_W-1:0]   tap_pc,
  input logic [DW-1:0]     tap_data,
  input logic [PC_W-1:0]   trap_l,
  input logic [PC_W-1:0]   trap_r,
  input logic [DW-1:0]     hold_l,
  input logic [DW-1:0]     hold_r,
  input logic              bit_fall,
  input logic              sdout
);
  import dcs_pkg::*;

  p_trap_l_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == ADDR_W'(TRAP_L_ADDR) |=> trap_l == $past(cfg_wdata));

  p_trap_r_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == ADDR_W'(TRAP_R_ADDR) |=> trap_r == $past(cfg_wdata));

  p_other_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr != ADDR_W'(TRAP_L_ADDR) && cfg_addr != ADDR_W'(TRAP_R_ADDR)
    |=> $stable(trap_l) && $stable(trap_r));

  p_capture_l_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tap_valid && tap_pc == trap_l |=> hold_l == $past(tap_data));

  p_capture_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tap_valid && tap_pc == trap_r |=> hold_r == $past(tap_data));

  p_no_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tap_valid |=> $stable(hold_l) && $stable(hold_r));

  p_fall_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_fall |=> $stable(sdout));
endmodule

bind dcs_capture_top dcs_capture_chk #(.ADDR_W(ADDR_W), .PC_W(PC_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .tap_valid(tap_valid), .tap_pc(tap_pc),
  .tap_data(tap_data), .trap_l(trap_l), .trap_r(trap_r),
  .hold_l(hold_l), .hold_r(hold_r), .bit_fall(bit_fall), .sdout(sdout)
);

// File: tb/sim_dcs_capture_top.sv
module sim_dcs_capture_top;
  localparam int ADDR_W = 9;
  localparam int PC_W   = 10;
  localparam int DW     = 24;
  localparam int SLOTS  = 32;
  localparam int HB     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fmt = 1'b0;
  logic cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [PC_W-1:0] cfg_wdata = '0;
  logic tap_valid = 1'b0;
  logic [PC_W-1:0] tap_pc = '0;
  logic [DW-1:0] tap_data = '0;
  logic bclk = 1'b1;
  logic lrclk = 1'b1;
  logic sdout;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [PC_W-1:0] m_trap_l = '0, m_trap_r = '0;
  logic [DW-1:0]   m_hold_l = '0, m_hold_r = '0;

  always #5 clk = ~clk;

  dcs_capture_top #(.ADDR_W(ADDR_W), .PC_W(PC_W), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tap_valid(tap_valid), .tap_pc(tap_pc),
    .tap_data(tap_data), .bclk(bclk), .lrclk(lrclk), .sdout(sdout)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [SLOTS-1:0] exp_slots(logic [DW-1:0] w, logic f);
    if (f == 1'b0) return {1'b0, w, {(SLOTS-DW-1){1'b0}}};
    return {w, {(SLOTS-DW){1'b0}}};
  endfunction

  task automatic check(string req, logic [SLOTS-1:0] act, logic [SLOTS-1:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_trap(int addr, logic [PC_W-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ADDR_W'(addr); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr == 263) m_trap_l = v;
    if (addr == 264) m_trap_r = v;
  endtask

  task automatic step(logic v, logic [PC_W-1:0] pc, logic [DW-1:0] d);
    @(negedge clk);
    tap_valid = v; tap_pc = pc; tap_data = d;
    @(negedge clk);
    tap_valid = 1'b0;
    if (v && pc == m_trap_l) m_hold_l = d;
    if (v && pc == m_trap_r) m_hold_r = d;
  endtask

  task automatic half(logic lr, output logic [SLOTS-1:0] bits);
    for (int i = 0; i < SLOTS; i++) begin
      @(negedge clk);
      bclk = 1'b0;
      if (i == 0) lrclk = lr;
      repeat (HB) @(negedge clk);
      bits[SLOTS-1-i] = sdout;
      bclk = 1'b1;
      repeat (HB) @(negedge clk);
    end
  endtask

  task automatic frame(string req);
    logic [SLOTS-1:0] lb, rb, el, er;
    logic left_lr;
    left_lr = (fmt == 1'b0) ? 1'b0 : 1'b1;
    el = exp_slots(m_hold_l, fmt);
    er = exp_slots(m_hold_r, fmt);
    half(left_lr, lb);
    half(~left_lr, rb);
    check({req, " left"}, lb, el);
    check({req, " right"}, rb, er);
  endtask

  task automatic rand_frame(string req);
    int n;
    n = 1 + ($urandom % 12);
    for (int k = 0; k < n; k++) begin
      logic [PC_W-1:0] pc;
      int sel;
      sel = $urandom % 4;
      pc = (sel == 0) ? m_trap_l : (sel == 1) ? m_trap_r : PC_W'($urandom);
      step(($urandom % 5) != 0, pc, DW'($urandom));
    end
    frame(req);
  endtask

  initial begin
    logic [SLOTS-1:0] junk;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    total = total + 1;
    if (sdout !== 1'b0) begin
      bad = bad + 1;
      $display("FAIL R9: sdout in reset actual=%b expected=0", sdout);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    total = total + 1;
    if (sdout !== 1'b0) begin
      bad = bad + 1;
      $display("FAIL R9: sdout after reset actual=%b expected=0", sdout);
    end
    frame("R9 empty frame");

    write_trap(263, 10'd5);
    write_trap(264, 10'd9);
    step(1'b1, 10'd5, 24'hA5C3F1);
    step(1'b1, 10'd9, 24'h81_0001);
    frame("R1 R3 R5 R7 directed");

    step(1'b1, 10'd6, 24'h111111);
    step(1'b1, 10'd8, 24'h222222);
    frame("R8 no hit repeat");

    write_trap(265, 10'd7);
    write_trap(262, 10'd7);
    step(1'b1, 10'd7, 24'h333333);
    frame("R2 other address");

    step(1'b0, 10'd5, 24'h444444);
    step(1'b0, 10'd9, 24'h555555);
    frame("R3 valid low");

    step(1'b1, 10'd5, 24'h010101);
    step(1'b1, 10'd5, 24'h020202);
    step(1'b1, 10'd5, 24'hFFFFFF);
    frame("R4 last hit");

    write_trap(264, 10'd5);
    step(1'b1, 10'd5, 24'h7E_5A3C);
    frame("R4 shared trap");

    write_trap(264, 10'd300);
    for (int f = 0; f < 10; f++) rand_frame("R5 R7 R8 random i2s");

    fmt = 1'b1;
    half(1'b1, junk);
    half(1'b0, junk);
    step(1'b1, 10'd5, 24'hC0FFEE);
    step(1'b1, 10'd300, 24'h800000);
    frame("R6 R7 directed lj");
    for (int f = 0; f < 8; f++) rand_frame("R6 R8 random lj");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule